// File: doc/BRIEF.md
# Printer Port Interrupt Controller

This block is the interrupt control and status register of a parallel printer port. It watches two inputs from the printer. On the acknowledge line it detects either the rising or the falling edge, and a register bit chooses which. On the fault line it detects the falling edge. Each detected event sets a sticky pending flag. Software reads the flags and clears each one by writing a 1 to its bit. While interrupts are enabled and any flag is pending, the block drives an interrupt request toward the processor, together with a programmable 3-bit priority level.

Both printer inputs pass through a two-flop synchronizer before edge detection. A change on a pin therefore reaches its pending flag on the third rising clock edge after the change.

The pending flags are held in a four-state machine:
- PEND_NONE: nothing pending.
- PEND_ACK: only the acknowledge event is pending.
- PEND_FLT: only the fault event is pending.
- PEND_BOTH: both events are pending.

In every state, an event sets its flag, and a clear that arrives without an event removes the flag. This gives the following transitions:
- PEND_NONE to PEND_ACK, PEND_FLT or PEND_BOTH on an event.
- PEND_ACK to PEND_NONE on an acknowledge clear.
- PEND_FLT to PEND_NONE on a fault clear.
- PEND_ACK or PEND_FLT to PEND_BOTH when the other event arrives.
- PEND_BOTH to PEND_ACK on a fault clear, to PEND_FLT on an acknowledge clear, and to PEND_NONE when both are cleared.
- Every state holds when nothing happens.

Top module: `prn_irq_ctrl`

## Requirements
- R1: After reset, rd_data reads 8'h00 and irq_req is 0. Interrupts are disabled, nothing is pending and the acknowledge edge is rising.
- R2: A write (wr_en=1) loads wr_data[4:0] into register bits 4:0, and they read back from the next cycle. Bits 2:0 hold the level, bit 3 is enable and bit 4 is the acknowledge edge select.
- R3: With bit 4 = 0, a rising edge on ack_in sets bit 5. With bit 4 = 1, a falling edge sets it. The opposite edge does not set it. The flag is visible on the third rising clock edge after the pin changes, and it stays set after the pin returns.
- R4: A falling edge on fault_in sets bit 6, with the same latency as R3. A rising edge does not set it.
- R5: Writing a 1 to bit 5 clears the acknowledge flag, and writing a 1 to bit 6 clears the fault flag. Writing a 0 to either bit leaves that flag unchanged.
- R6: A write with bit 3 = 0 clears the acknowledge flag and leaves the fault flag unchanged.
- R7: When an edge event and a clear of the same flag fall in the same cycle, the flag is set.
- R8: Bit 7 reads as the OR of bits 5 and 6, and writes to bit 7 have no effect.
- R9: irq_req is 1 exactly when bits 3 and 7 are both 1. irq_level equals bits 2:0 while irq_req is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| ack_in | input | 1 | Printer acknowledge, asynchronous |
| fault_in | input | 1 | Printer fault, asynchronous |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Level of the request |

## Verification
The assertions assume that wr_en and wr_data are stable around the clock edge. They also assume that ack_in and fault_in may change at any cycle, because the synchronizer absorbs their timing. The stimulus drives every input only on the falling clock edge, and it toggles the printer pins at random, including on back-to-back cycles. This exercises edges that arrive together with writes. Random writes cover all byte values, so clears, disables and polarity changes meet live events.

// File: rtl/prn_irq_pkg.sv
package prn_irq_pkg;
    localparam int DATA_W = 8;
    localparam int LVL_W  = 3;
    localparam int CFG_W  = LVL_W + 2;

    typedef enum logic [1:0] {
        PEND_NONE = 2'b00,
        PEND_ACK  = 2'b01,
        PEND_FLT  = 2'b10,
        PEND_BOTH = 2'b11
    } pend_state_t;

    typedef struct packed {
        logic             ack_fall;
        logic             enable;
        logic [LVL_W-1:0] level;
    } cfg_t;

    function automatic pend_state_t pend_encode(input logic flt, input logic ack);
        return pend_state_t'({flt, ack});
    endfunction
endpackage

// File: rtl/prn_sync_edge.sv
module prn_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic sig_cur,
    output logic sig_prev
);
    logic [STAGES-1:0] chain;
    logic              hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            hist  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], sig_in};
            hist  <= chain[STAGES-1];
        end
    end

    assign sig_cur  = chain[STAGES-1];
    assign sig_prev = hist;
endmodule

// File: rtl/prn_cfg_reg.sv
module prn_cfg_reg
    import prn_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_cfg,
    output cfg_t             cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cfg <= '0;
        else if (wr_en) cfg <= cfg_t'(wr_cfg);
    end

    assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg == cfg_t'($past(wr_cfg)));
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));
endmodule

// File: rtl/prn_pend_fsm.sv
module prn_pend_fsm
    import prn_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_set,
    input  logic ack_clr,
    input  logic flt_set,
    input  logic flt_clr,
    output logic ack_pend,
    output logic flt_pend
);
    pend_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PEND_NONE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PEND_NONE: state_nx = pend_encode(flt_set, ack_set);
            PEND_ACK:  state_nx = pend_encode(flt_set, ack_set | ~ack_clr);
            PEND_FLT:  state_nx = pend_encode(flt_set | ~flt_clr, ack_set);
            PEND_BOTH: state_nx = pend_encode(flt_set | ~flt_clr, ack_set | ~ack_clr);
            default:   state_nx = PEND_NONE;
        endcase
    end

    always_comb begin
        ack_pend = 1'b0;
        flt_pend = 1'b0;
        unique case (state)
            PEND_NONE: begin ack_pend = 1'b0; flt_pend = 1'b0; end
            PEND_ACK:  begin ack_pend = 1'b1; flt_pend = 1'b0; end
            PEND_FLT:  begin ack_pend = 1'b0; flt_pend = 1'b1; end
            PEND_BOTH: begin ack_pend = 1'b1; flt_pend = 1'b1; end
            default:   begin ack_pend = 1'b0; flt_pend = 1'b0; end
        endcase
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_set |=> ack_pend);
    assert_flt_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flt_set |=> flt_pend);
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !ack_set) |=> !ack_pend);
    assert_flt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_clr && !flt_set) |=> !flt_pend);
    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_set && !ack_clr && !flt_set && !flt_clr) |=> $stable(state));
endmodule

// File: rtl/prn_irq_ctrl.sv
module prn_irq_ctrl
    import prn_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack_in,
    input  logic              fault_in,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level
);
    localparam int N_CHAN  = 2;
    localparam int BIT_EN  = LVL_W;
    localparam int BIT_ACK = LVL_W + 2;
    localparam int BIT_FLT = LVL_W + 3;

    logic [N_CHAN-1:0] pin_raw, pin_cur, pin_prev;
    cfg_t cfg;
    logic ack_set, ack_clr, flt_set, flt_clr;
    logic ack_pend, flt_pend, any_pend;

    assign pin_raw = {fault_in, ack_in};

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        prn_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_in   (pin_raw[c]),
            .sig_cur  (pin_cur[c]),
            .sig_prev (pin_prev[c])
        );
    end

    prn_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_cfg (wr_data[CFG_W-1:0]),
        .cfg    (cfg)
    );

    always_comb begin
        if (cfg.ack_fall) ack_set = pin_prev[0] & ~pin_cur[0];
        else              ack_set = pin_cur[0] & ~pin_prev[0];
        flt_set = pin_prev[1] & ~pin_cur[1];
        ack_clr = wr_en & (wr_data[BIT_ACK] | ~wr_data[BIT_EN]);
        flt_clr = wr_en & wr_data[BIT_FLT];
    end

    prn_pend_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_set  (ack_set),
        .ack_clr  (ack_clr),
        .flt_set  (flt_set),
        .flt_clr  (flt_clr),
        .ack_pend (ack_pend),
        .flt_pend (flt_pend)
    );

    assign any_pend  = ack_pend | flt_pend;
    assign rd_data   = {any_pend, flt_pend, ack_pend, cfg};
    assign irq_req   = cfg.enable & any_pend;
    assign irq_level = irq_req ? cfg.level : '0;

    assert_disable_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[BIT_EN] && !ack_set && !flt_set && !wr_data[BIT_FLT])
        |=> !rd_data[BIT_ACK] && $stable(rd_data[BIT_FLT]));
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_level == '0);
    assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ack_set && !flt_set && !ack_pend && !flt_pend) |=> !rd_data[DATA_W-1]);
endmodule

// File: tb/prn_irq_ctrl_test.sv
module prn_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n, wr_en, ack_in, fault_in;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq_req;
    logic [2:0] irq_level;

    always #5 clk = ~clk;

    prn_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ack_in(ack_in), .fault_in(fault_in),
        .irq_req(irq_req), .irq_level(irq_level)
    );

    int n_run = 0, n_fail = 0;
    logic [2:0] ma, mf;
    logic [4:0] m_cfg;
    logic       m_ack, m_flt;

    function automatic logic [7:0] exp_rd();
        return {m_ack | m_flt, m_flt, m_ack, m_cfg};
    endfunction

    function automatic logic [3:0] exp_irq();
        logic r;
        r = m_cfg[3] & (m_ack | m_flt);
        return {r, r ? m_cfg[2:0] : 3'b000};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2 config bits", {3'b0, rd_data[4:0]}, {3'b0, m_cfg});
        check("R3 ack flag", {7'b0, rd_data[5]}, {7'b0, m_ack});
        check("R4 fault flag", {7'b0, rd_data[6]}, {7'b0, m_flt});
        check("R8 summary bit", {7'b0, rd_data[7]}, {7'b0, m_ack | m_flt});
        check("R9 request", {4'b0, irq_req, irq_level}, {4'b0, exp_irq()});
    endtask

    task automatic tick();
        logic ae, fe, ac, fc;
        ae = m_cfg[4] ? (ma[2] & ~ma[1]) : (ma[1] & ~ma[2]);
        fe = mf[2] & ~mf[1];
        ac = wr_en & (wr_data[5] | ~wr_data[3]);
        fc = wr_en & wr_data[6];
        @(posedge clk);
        m_ack = ae | (m_ack & ~ac);
        m_flt = fe | (m_flt & ~fc);
        if (wr_en) m_cfg = wr_data[4:0];
        ma = {ma[1], ma[0], ack_in};
        mf = {mf[1], mf[0], fault_in};
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ack_in = 1'b0; fault_in = 1'b0;
        ma = '0; mf = '0; m_cfg = '0; m_ack = 1'b0; m_flt = 1'b0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset rd_data", rd_data, 8'h00);
        check("R1 reset irq", {7'b0, irq_req}, 8'h00);

        wr(8'h0D);
        check("R2 readback", rd_data, 8'h0D);
        ack_in = 1'b1; ticks(2);
        check("R3 latency not yet", {7'b0, rd_data[5]}, 8'h00);
        tick();
        check("R3 rising edge sets", {7'b0, rd_data[5]}, 8'h01);
        check("R9 level on request", {4'b0, irq_req, irq_level}, 8'h0D);
        ack_in = 1'b0; ticks(4);
        check("R3 sticky after release", {7'b0, rd_data[5]}, 8'h01);
        wr(8'h0D);
        check("R5 zero write keeps flag", {7'b0, rd_data[5]}, 8'h01);
        wr(8'h2D);
        check("R5 w1c ack", {7'b0, rd_data[5]}, 8'h00);

        wr(8'h1D);
        ack_in = 1'b1; ticks(4);
        check("R3 rising ignored when falling selected", {7'b0, rd_data[5]}, 8'h00);
        ack_in = 1'b0; ticks(3);
        check("R3 falling edge sets", {7'b0, rd_data[5]}, 8'h01);
        fault_in = 1'b1; ticks(4);
        check("R4 rising fault ignored", {7'b0, rd_data[6]}, 8'h00);
        fault_in = 1'b0; ticks(3);
        check("R4 falling fault sets", {7'b0, rd_data[6]}, 8'h01);
        wr(8'h9D);
        check("R8 write to bit7 ignored", rd_data, 8'hFD);
        wr(8'h10);
        check("R6 disable clears ack keeps fault", rd_data, 8'hD0);
        check("R9 no request when disabled", {7'b0, irq_req}, 8'h00);
        wr(8'h50);
        check("R5 w1c fault", rd_data, 8'h10);

        wr(8'h08);
        ack_in = 1'b1; ticks(2);
        wr(8'h28);
        check("R7 set wins over clear", {7'b0, rd_data[5]}, 8'h01);
        ack_in = 1'b0;
        wr(8'h68);
        ticks(4);

        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 6 == 0) ack_in = ~ack_in;
            if ($urandom % 7 == 0) fault_in = ~fault_in;
            if ($urandom % 5 == 0) begin
                wr_en = 1'b1; wr_data = 8'($urandom);
            end
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule